// File: doc/BRIEF.md
# Oversampled Asynchronous Receiver with Wake-up Filter

This block receives asynchronous serial frames. Each frame has a start bit, 8 data bits sent LSB first, an optional ninth bit and one stop bit. A tick input pulses at OSR times the baud rate, and the block samples the synchronized line once per tick. The value of each bit is the majority of three samples taken around the middle of the bit slot. A start bit whose voted value is not 0 is treated as noise, and the receiver goes back to waiting.

When the stop bit has been voted, the data moves into a receive buffer and a one-cycle receive-interrupt pulse is raised. A framing-error flag goes out with that pulse when the voted stop bit is 0. In wake-up mode every frame carries a ninth bit, and a frame whose ninth bit is 0 is dropped without a trace. Clearing the enable lets a frame already in progress finish, and no new frame starts after that.

The controller is a five-state machine:
- IDLE: waits for a low line that follows a high line, with the enable set.
- START: votes the start bit. A voted 1 goes back to IDLE and a voted 0 goes on to DATA.
- DATA: shifts in the data bits. After the last one it goes to NINTH or STOP.
- NINTH: votes the ninth bit and goes to STOP.
- STOP: votes the stop bit, commits the frame or drops it, and goes to IDLE.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset, rx_data is 0 and rx_bit9, rx_irq and frame_err are all 0.
- R2: A frame starts only while rx_en is 1. While rx_en is 0 and the receiver is idle, a low line starts nothing, rx_irq stays 0 and rx_data keeps its value.
- R3: Each bit takes the majority of the samples at tick indices OSR/2-2, OSR/2-1 and OSR/2 of its slot. These are the 7th, 8th and 9th samples when OSR is 16. A single inverted sample inside that window does not change the received bit.
- R4: If the start bit votes 1, the receiver returns to idle with no interrupt, and the next valid frame is received normally.
- R5: Data bits arrive LSB first, and the first data bit lands in rx_data[0]. In a frame without a ninth bit, rx_bit9 is 0 when the frame is committed.
- R6: When nine_bit is 1 at the start bit, one more bit follows the data bits. Its voted value appears on rx_bit9 when the frame is committed.
- R7: rx_irq is a pulse one clock long, raised after the stop bit's vote. rx_data and rx_bit9 take their new values in the same clock and do not change in any other clock.
- R8: If the stop bit votes 0, frame_err is 1 in the same clock as the rx_irq pulse and the data is still transferred. At all other times frame_err is 0.
- R9: When wake_mode is 1 at the start bit, the frame carries a ninth bit. If that bit is 0, rx_data is not updated and no rx_irq is raised. If it is 1, the frame is committed normally with rx_bit9 = 1.
- R10: If rx_en is cleared during a frame, that frame still completes with its interrupt. No later frame is received while rx_en stays 0.
- R11: After a frame, a new start is recognized only once the line has been seen high. A line that stays low after a bad stop bit produces no further frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial input line, idle high |
| tick16 | input | 1 | One-clock pulse at OSR times the baud rate |
| rx_en | input | 1 | Receive enable |
| wake_mode | input | 1 | Wake-up filtering, sampled at the start bit |
| nine_bit | input | 1 | Ninth-bit frame format, sampled at the start bit |
| rx_data | output | DATA_W | Receive buffer |
| rx_bit9 | output | 1 | Ninth bit of the last committed frame |
| rx_irq | output | 1 | Receive interrupt pulse |
| frame_err | output | 1 | Framing error, valid with rx_irq |

## Verification
The bench builds the block with its defaults: OSR = 16, DATA_W = 8 and two synchronizer stages. It drives tick16 once every 4 clocks, so one bit slot is 64 clocks. With that ratio the bench can place a one-tick glitch inside the three-sample voting window, and a short low pulse that ends before the window, so both the majority vote and start-bit rejection can be tested. The 8-bit data width lets the bench hold easy-to-read patterns in the buffer and confirm that dropped wake-up frames and disabled frames leave the buffer untouched.

// File: rtl/uwr_pkg.sv
package uwr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_NINTH,
        ST_STOP
    } rx_state_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uwr_sync.sv
module uwr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uwr_voter.sv
module uwr_voter import uwr_pkg::*; #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic din,
    output logic vote_valid,
    output logic vote_val
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] IDX_A    = CW'(OSR / 2 - 2);
    localparam logic [CW-1:0] IDX_B    = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] IDX_C    = CW'(OSR / 2);
    localparam logic [CW-1:0] IDX_LAST = CW'(OSR - 1);

    logic [CW-1:0] cnt_q;
    logic          samp_a_q;
    logic          samp_b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == IDX_LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_a_q   <= 1'b1;
            samp_b_q   <= 1'b1;
            vote_valid <= 1'b0;
            vote_val   <= 1'b1;
        end else begin
            vote_valid <= 1'b0;
            if (!clear && tick) begin
                if (cnt_q == IDX_A) samp_a_q <= din;
                if (cnt_q == IDX_B) samp_b_q <= din;
                if (cnt_q == IDX_C) begin
                    vote_valid <= 1'b1;
                    vote_val   <= maj3(samp_a_q, samp_b_q, din);
                end
            end
        end
    end
endmodule

// File: rtl/uwr_shift.sv
module uwr_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] data
);
    generate
        if (W == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        data <= '0;
                else if (clr)      data <= '0;
                else if (shift_en) data <= bit_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        data <= '0;
                else if (clr)      data <= '0;
                else if (shift_en) data <= {bit_in, data[W-1:1]};
            end
        end
    endgenerate
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx import uwr_pkg::*; #(
    parameter int OSR         = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              tick16,
    input  logic              rx_en,
    input  logic              wake_mode,
    input  logic              nine_bit,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_irq,
    output logic              frame_err
);
    localparam int BCW = $clog2(DATA_W + 1);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_W - 1);

    rx_state_e          state_q, state_d;
    logic [BCW-1:0]     bit_cnt_q, bit_cnt_d;
    logic               line_s;
    logic               vote_valid, vote_val;
    logic               armed_q, wake_q, has9_q, bit9_q;
    logic               start_frame, shift_en, commit;
    logic [DATA_W-1:0]  shift_data;

    uwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (line_s)
    );

    uwr_voter #(.OSR(OSR)) u_voter (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state_q == ST_IDLE),
        .tick      (tick16),
        .din       (line_s),
        .vote_valid(vote_valid),
        .vote_val  (vote_val)
    );

    uwr_shift #(.W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_frame),
        .shift_en(shift_en),
        .bit_in  (vote_val),
        .data    (shift_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
        end else begin
            state_q   <= state_d;
            bit_cnt_q <= bit_cnt_d;
        end
    end

    // Next state and frame control
    always_comb begin
        state_d     = state_q;
        bit_cnt_d   = bit_cnt_q;
        start_frame = 1'b0;
        shift_en    = 1'b0;
        commit      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rx_en && armed_q && !line_s) begin
                    state_d     = ST_START;
                    start_frame = 1'b1;
                end
            end
            ST_START: begin
                if (vote_valid) begin
                    if (vote_val) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d   = ST_DATA;
                        bit_cnt_d = '0;
                    end
                end
            end
            ST_DATA: begin
                if (vote_valid) begin
                    shift_en = 1'b1;
                    if (bit_cnt_q == LAST_BIT) begin
                        state_d = has9_q ? ST_NINTH : ST_STOP;
                    end else begin
                        bit_cnt_d = bit_cnt_q + 1'b1;
                    end
                end
            end
            ST_NINTH: begin
                if (vote_valid) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (vote_valid) begin
                    state_d = ST_IDLE;
                    commit  = !(wake_q && !bit9_q);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Per-frame context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            wake_q  <= 1'b0;
            has9_q  <= 1'b0;
            bit9_q  <= 1'b0;
        end else begin
            if (start_frame) begin
                armed_q <= 1'b0;
                wake_q  <= wake_mode;
                has9_q  <= nine_bit | wake_mode;
                bit9_q  <= 1'b0;
            end else begin
                if (state_q == ST_IDLE && line_s) armed_q <= 1'b1;
                if (state_q == ST_NINTH && vote_valid) bit9_q <= vote_val;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_bit9   <= 1'b0;
            rx_irq    <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            rx_irq    <= commit;
            frame_err <= commit && !vote_val;
            if (commit) begin
                rx_data <= shift_data;
                rx_bit9 <= has9_q & bit9_q;
            end
        end
    end
endmodule

// File: rtl/uwr_checker.sv
module uwr_checker import uwr_pkg::*; #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              rx_irq,
    input logic              frame_err,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_bit9,
    input rx_state_e         state,
    input logic              wake_q,
    input logic              has9_q
);
    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    assert_buf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_irq |-> ($stable(rx_data) && $stable(rx_bit9)));

    assert_err_with_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> rx_irq);

    assert_wake_bit9_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && wake_q) |-> rx_bit9);

    assert_eight_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && !has9_q) |-> !rx_bit9);

    assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !rx_en) |=> (state == ST_IDLE));
endmodule

bind uart_wake_rx uwr_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .rx_irq   (rx_irq),
    .frame_err(frame_err),
    .rx_data  (rx_data),
    .rx_bit9  (rx_bit9),
    .state    (state_q),
    .wake_q   (wake_q),
    .has9_q   (has9_q)
);

// File: tb/uart_wake_rx_test.sv
module uart_wake_rx_test;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int OSR        = 16;
    localparam int DATA_W     = 8;
    localparam int BIT_CLKS   = OSR * TICK_DIV;

    logic clk = 0;
    logic rst_n = 0;
    logic rx_line = 1;
    logic tick16 = 0;
    logic rx_en = 0;
    logic wake_mode = 0;
    logic nine_bit = 0;
    logic [DATA_W-1:0] rx_data;
    logic rx_bit9, rx_irq, frame_err;

    int checks = 0;
    int failures = 0;
    int irq_seen = 0;
    int wide_irq = 0;
    logic [DATA_W-1:0] cap_data = '0;
    logic cap_b9 = 0;
    logic cap_err = 0;
    logic irq_d = 0;
    int div = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        div    <= (div == TICK_DIV-1) ? 0 : div + 1;
        tick16 <= (div == TICK_DIV-1);
    end

    uart_wake_rx #(.OSR(OSR), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
        .rx_en(rx_en), .wake_mode(wake_mode), .nine_bit(nine_bit),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_irq(rx_irq), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        irq_d <= rx_irq;
        if (rx_irq) begin
            irq_seen <= irq_seen + 1;
            cap_data <= rx_data;
            cap_b9   <= rx_bit9;
            cap_err  <= frame_err;
            if (irq_d) wide_irq <= wide_irq + 1;
        end
        if (frame_err && !rx_irq) wide_irq <= wide_irq + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int clks);
        @(negedge clk);
        rx_line = v;
        repeat (clks - 1) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic with9, input logic b9,
                              input logic stopv, input int glitch, input int drop_en);
        hold(1'b0, BIT_CLKS);
        for (int i = 0; i < DATA_W; i++) begin
            if (i == drop_en) rx_en = 1'b0;
            if (i == glitch) begin
                hold(d[i], 30);
                hold(~d[i], 4);
                hold(d[i], BIT_CLKS - 34);
            end else begin
                hold(d[i], BIT_CLKS);
            end
        end
        if (with9) hold(b9, BIT_CLKS);
        hold(stopv, BIT_CLKS);
    endtask

    task automatic idle_bits(input int n);
        hold(1'b1, n * BIT_CLKS);
    endtask

    task automatic t_reset;
        chk("R1 rx_data", rx_data, 0);
        chk("R1 rx_bit9", rx_bit9, 0);
        chk("R1 rx_irq", rx_irq, 0);
        chk("R1 frame_err", frame_err, 0);
    endtask

    task automatic t_basic8;
        int base = irq_seen;
        rx_en = 1; nine_bit = 0; wake_mode = 0;
        idle_bits(2);
        send_frame(8'hA5, 0, 0, 1, -1, -1);
        idle_bits(2);
        chk("R7 irq count", irq_seen - base, 1);
        chk("R5 data lsb first", cap_data, 8'hA5);
        chk("R5 bit9 zero in 8-bit", cap_b9, 0);
        chk("R8 no err on good stop", cap_err, 0);
        chk("R7 buffer held", rx_data, 8'hA5);
    endtask

    task automatic t_nine;
        int base = irq_seen;
        nine_bit = 1;
        send_frame(8'h3C, 1, 1, 1, -1, -1);
        idle_bits(2);
        chk("R6 irq count", irq_seen - base, 1);
        chk("R6 data", cap_data, 8'h3C);
        chk("R6 bit9 one", cap_b9, 1);
        send_frame(8'h81, 1, 0, 1, -1, -1);
        idle_bits(2);
        chk("R6 bit9 zero", cap_b9, 0);
        chk("R6 data second", cap_data, 8'h81);
        nine_bit = 0;
    endtask

    task automatic t_majority;
        send_frame(8'h5A, 0, 0, 1, 3, -1);
        idle_bits(2);
        chk("R3 glitch on bit3", cap_data, 8'h5A);
        send_frame(8'h96, 0, 0, 1, 0, -1);
        idle_bits(2);
        chk("R3 glitch on bit0", cap_data, 8'h96);
    endtask

    task automatic t_false_start;
        int base = irq_seen;
        hold(1'b0, 12);
        idle_bits(3);
        chk("R4 no irq after short low", irq_seen - base, 0);
        chk("R4 buffer unchanged", rx_data, 8'h96);
        send_frame(8'h11, 0, 0, 1, -1, -1);
        idle_bits(2);
        chk("R4 recovered frame", cap_data, 8'h11);
    endtask

    task automatic t_ferr;
        int base = irq_seen;
        send_frame(8'h77, 0, 0, 0, -1, -1);
        hold(1'b0, 3 * BIT_CLKS);
        chk("R8 irq on bad stop", irq_seen - base, 1);
        chk("R8 frame_err set", cap_err, 1);
        chk("R8 data transferred", cap_data, 8'h77);
        chk("R11 no restart while low", irq_seen - base, 1);
        idle_bits(2);
        send_frame(8'h22, 0, 0, 1, -1, -1);
        idle_bits(2);
        chk("R11 frame after high", cap_data, 8'h22);
        chk("R8 err clear on good frame", cap_err, 0);
    endtask

    task automatic t_wake;
        int base = irq_seen;
        wake_mode = 1; nine_bit = 0;
        send_frame(8'h44, 1, 0, 1, -1, -1);
        idle_bits(2);
        chk("R9 discard irq", irq_seen - base, 0);
        chk("R9 discard buffer", rx_data, 8'h22);
        send_frame(8'h66, 1, 1, 1, -1, -1);
        idle_bits(2);
        chk("R9 accept irq", irq_seen - base, 1);
        chk("R9 accept data", cap_data, 8'h66);
        chk("R9 accept bit9", cap_b9, 1);
        wake_mode = 0;
    endtask

    task automatic t_disabled;
        int base = irq_seen;
        rx_en = 0;
        send_frame(8'h99, 0, 0, 1, -1, -1);
        idle_bits(2);
        chk("R2 no irq when off", irq_seen - base, 0);
        chk("R2 buffer unchanged", rx_data, 8'h66);
        rx_en = 1;
        idle_bits(1);
    endtask

    task automatic t_disable_mid;
        int base = irq_seen;
        send_frame(8'h3D, 0, 0, 1, -1, 3);
        idle_bits(2);
        chk("R10 frame finishes", irq_seen - base, 1);
        chk("R10 data", cap_data, 8'h3D);
        send_frame(8'hC3, 0, 0, 1, -1, -1);
        idle_bits(2);
        chk("R10 later frame ignored", irq_seen - base, 1);
        chk("R10 buffer kept", rx_data, 8'h3D);
    endtask

    task automatic finish_run;
        chk("R7 irq width one and err only with irq", wide_irq, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset;
        rst_n = 1;
        repeat (5) @(negedge clk);
        t_reset;
        t_basic8;
        t_nine;
        t_majority;
        t_false_start;
        t_ferr;
        t_wake;
        t_disabled;
        t_disable_mid;
        finish_run;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule